// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes for a network interface and drives a single level interrupt line to the host. It holds a 32-bit cause register, whose top bit (bit 31) mirrors the state of the line, a 31-bit mask and a 31-bit auto-mask. Internal event sources post cause bits as single-cycle pulses, and they may ask for immediate delivery. The host reaches the registers through a one-cycle access port. A three-bit operation code selects one of these operations: read cause, clear causes, set causes, set mask bits, clear mask bits, write auto-mask, read mask, read auto-mask.

A throttle interval delays the first assertion of the line. The delay is counted in periods of an external 256 ns strobe, and it is used only when no unmasked cause is already waiting. Reading the cause register can clear it and drop the line. Whether it does depends on the mask, the auto-mask and an auto-mask-enable input. Inside one clock cycle the block applies the throttle expiry first, then the host operation, then the posting of new causes.

Top module: `irq_cause_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the cause, mask and auto-mask registers, the read data and the throttle timer. irq_out is low after reset.
- R2: Operation code 1 (clear causes) clears every bit of cause[30:0] that is written as one. When no bit of cause[30:0] is left, bit 31 and irq_out drop.
- R3: On operation code 0 (read cause) or code 1 (clear causes), if cause bit 31 is set, the mask is first replaced by mask AND auto-mask.
- R4: Operation code 0 returns the cause value in rd_data. The whole cause register, including bit 31, is then cleared if the mask (after R3) is zero, or if bit 31 is set and amask_on_ack is high. Otherwise the cause register is kept.
- R5: Operation code 3 ORs wdata into the mask. Operation code 4 clears the mask bits written as one. After either one, bit 31 and irq_out drop if no bit of cause[30:0] is unmasked.
- R6: Posted bits that are already set in the cause register are ignored. If an unmasked cause is already pending, new bits are only ORed in and no new assertion starts.
- R7: A new cause bit that is masked is recorded in the cause register but does not assert irq_out.
- R8: A new unmasked cause, posted while no unmasked cause is pending, asserts irq_out on the next clock edge when thr_interval is zero or ev_urgent is high. An urgent assertion cancels any running throttle timer.
- R9: Otherwise the throttle timer loads thr_interval, unless it is already running. It asserts irq_out (and sets bit 31) on the edge where the thr_interval-th tick_256ns pulse is seen. The timer is abandoned whenever cause[30:0] becomes all zero.
- R10: Operation code 2 (set causes) posts wdata as new causes. When it coincides with ev_post, both sets of bits are merged into one posting, which uses the urgency given by ev_urgent.
- R11: Operation code 6 returns the mask and code 7 returns the auto-mask, zero-extended. Operation code 5 writes the auto-mask. rd_data changes one edge after a read operation (codes 0, 6, 7) and holds at all other times.
- R12: Within one cycle the order is: throttle expiry, then the host operation, then the posting of new causes. With no access, no posting and no tick, the cause register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_256ns | input | 1 | One-cycle strobe every 256 ns, used by the throttle timer |
| acc_valid | input | 1 | Host access strobe for this cycle |
| acc_op | input | 3 | Host operation code (0 to 7, see R2 to R11) |
| acc_wdata | input | 31 | Host write data (bit 31 of a write has no effect and is not carried) |
| rd_data | output | 32 | Registered read data |
| ev_post | input | 31 | Cause bits posted by internal event sources |
| ev_urgent | input | 1 | Immediate delivery request for this cycle's posting |
| thr_interval | input | 16 | Throttle interval in 256 ns units; zero disables throttling |
| amask_on_ack | input | 1 | Auto-mask enable: lets a cause read clear while the line is asserted |
| irq_out | output | 1 | Interrupt line to the host (equal to cause bit 31) |

## Verification
Every effect of a host operation or a posting appears on irq_out and rd_data one rising edge after the cycle in which it is driven. The bench drives inputs on the falling edge and samples on the next falling edge, so each result is read half a period after the edge that makes it. A throttled assertion is due on the edge that sees the thr_interval-th tick strobe. The directed cases therefore check the line low after one tick fewer than that, and high after the last one. A bench model applies the expiry, host-operation and posting steps in the order given in R12, and it is compared with the outputs every cycle of the random phase.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared operation codes for the interrupt cause and mask controller.
// Assumes a 3-bit host operation field; the code values are part of the port contract.
package irq_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_CAUSE_RD  = 3'd0,
        OP_CAUSE_CLR = 3'd1,
        OP_CAUSE_SET = 3'd2,
        OP_MASK_SET  = 3'd3,
        OP_MASK_CLR  = 3'd4,
        OP_AMASK_WR  = 3'd5,
        OP_MASK_RD   = 3'd6,
        OP_AMASK_RD  = 3'd7
    } host_op_e;

endpackage

// File: rtl/irq_throttle.sv
// Module: throttle down-counter. It counts tick strobes after a load and flags
// expiry on the tick that ends the interval.
// Assumes load_val is nonzero whenever load is raised; cancel wins over load.
module irq_throttle #(
    parameter int IV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic [IV_W-1:0] load_val,
    input  logic            cancel,
    output logic            running,
    output logic            expire
);

    localparam logic [IV_W-1:0] ONE = IV_W'(1);

    logic [IV_W-1:0] cnt_q;
    logic            run_q;

    // Expiry: the running counter sees its last tick in this cycle.
    always_comb begin
        expire = run_q && tick && (cnt_q == ONE);
    end

    assign running = run_q;

    // Counter state: cancel, reload, expire or count one tick down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (cancel) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= load_val;
        end else if (expire) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/irq_mask_regs.sv
// Module: mask and auto-mask storage. It computes the mask value that the cause
// logic must see in this cycle, and registers it.
// Assumes asrt_pre is the line state after this cycle's throttle expiry.
module irq_mask_regs
    import irq_ctrl_pkg::*;
#(
    parameter int MW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [2:0]    acc_op,
    input  logic [MW-1:0] acc_wdata,
    input  logic          asrt_pre,
    output logic [MW-1:0] mask_next,
    output logic [MW-1:0] mask_q,
    output logic [MW-1:0] amask_q
);

    logic [MW-1:0] amask_next;
    host_op_e      op;

    assign op = host_op_e'(acc_op);

    // Next mask and auto-mask from the host operation of this cycle.
    always_comb begin
        mask_next  = mask_q;
        amask_next = amask_q;
        if (acc_valid) begin
            case (op)
                OP_CAUSE_RD, OP_CAUSE_CLR: if (asrt_pre) mask_next = mask_q & amask_q;
                OP_MASK_SET:  mask_next  = mask_q | acc_wdata;
                OP_MASK_CLR:  mask_next  = mask_q & ~acc_wdata;
                OP_AMASK_WR:  amask_next = acc_wdata;
                default:      ;
            endcase
        end
    end

    // Register the mask and the auto-mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            amask_q <= '0;
        end else begin
            mask_q  <= mask_next;
            amask_q <= amask_next;
        end
    end

endmodule

// File: rtl/irq_cause_core.sv
// Module: cause register and line control. It applies throttle expiry, then
// the host operation, then the merged posting, and tells the timer what to do.
// Assumes mask_next already includes this cycle's host effect on the mask.
module irq_cause_core
    import irq_ctrl_pkg::*;
#(
    parameter int CW   = 32,
    parameter int IV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [2:0]      acc_op,
    input  logic [CW-2:0]   acc_wdata,
    input  logic [CW-2:0]   ev_post,
    input  logic            ev_urgent,
    input  logic            amask_on_ack,
    input  logic [IV_W-1:0] thr_interval,
    input  logic [CW-2:0]   mask_next,
    input  logic            t_running,
    input  logic            t_expire,
    output logic [CW-1:0]   cause_q,
    output logic            asrt_pre,
    output logic            t_load,
    output logic            t_cancel
);

    localparam int LW   = CW - 1;
    localparam int FLAG = CW - 1;

    logic [CW-1:0] c_exp, c_host, c_next;
    logic [LW-1:0] post_bits, new_bits;
    host_op_e      op;

    assign op = host_op_e'(acc_op);

    // Step 1: a throttle expiry raises the asserted flag.
    always_comb begin
        c_exp = cause_q;
        if (t_expire) c_exp[FLAG] = 1'b1;
        asrt_pre = c_exp[FLAG];
    end

    // Step 2: host operation on the cause register.
    always_comb begin
        c_host = c_exp;
        if (acc_valid) begin
            case (op)
                OP_CAUSE_RD: begin
                    if ((mask_next == '0) || (c_exp[FLAG] && amask_on_ack))
                        c_host = '0;
                end
                OP_CAUSE_CLR: begin
                    c_host[LW-1:0] = c_exp[LW-1:0] & ~acc_wdata;
                    if (c_host[LW-1:0] == '0) c_host[FLAG] = 1'b0;
                end
                OP_MASK_SET, OP_MASK_CLR: begin
                    if ((c_exp[LW-1:0] & mask_next) == '0) c_host[FLAG] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Step 3: merged posting from the events and the host set operation.
    always_comb begin
        post_bits = ev_post;
        if (acc_valid && (op == OP_CAUSE_SET)) post_bits = post_bits | acc_wdata;
        new_bits = post_bits & ~c_host[LW-1:0];
        c_next   = c_host;
        t_load   = 1'b0;
        t_cancel = 1'b0;
        if (new_bits != '0) begin
            c_next[LW-1:0] = c_host[LW-1:0] | new_bits;
            if (((c_host[LW-1:0] & mask_next) == '0) && ((new_bits & mask_next) != '0)) begin
                if ((thr_interval == '0) || ev_urgent) begin
                    c_next[FLAG] = 1'b1;
                    t_cancel     = 1'b1;
                end else if (!t_running || t_expire) begin
                    t_load = 1'b1;
                end
            end
        end
        if (c_next[LW-1:0] == '0) t_cancel = 1'b1;
    end

    // Cause register update.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= c_next;
    end

endmodule

// File: rtl/irq_cause_ctrl.sv
// Module: top of the interrupt cause and mask controller. It ties together the
// mask storage, the cause logic and the throttle timer, and registers read data.
// Assumes tick_256ns is a one-cycle strobe and that at most one host access
// arrives per cycle.
module irq_cause_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int CAUSE_W = 32,
    parameter int IV_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_256ns,
    input  logic               acc_valid,
    input  logic [2:0]         acc_op,
    input  logic [CAUSE_W-2:0] acc_wdata,
    output logic [CAUSE_W-1:0] rd_data,
    input  logic [CAUSE_W-2:0] ev_post,
    input  logic               ev_urgent,
    input  logic [IV_W-1:0]    thr_interval,
    input  logic               amask_on_ack,
    output logic               irq_out
);

    localparam int LW = CAUSE_W - 1;

    logic [CAUSE_W-1:0] cause_q;
    logic [LW-1:0]      mask_next, mask_q, amask_q;
    logic               asrt_pre, t_load, t_cancel, t_running, t_expire;
    logic [CAUSE_W-1:0] rd_q;
    host_op_e           op;

    assign op = host_op_e'(acc_op);

    irq_mask_regs #(.MW(LW)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_op    (acc_op),
        .acc_wdata (acc_wdata),
        .asrt_pre  (asrt_pre),
        .mask_next (mask_next),
        .mask_q    (mask_q),
        .amask_q   (amask_q)
    );

    irq_cause_core #(.CW(CAUSE_W), .IV_W(IV_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_op       (acc_op),
        .acc_wdata    (acc_wdata),
        .ev_post      (ev_post),
        .ev_urgent    (ev_urgent),
        .amask_on_ack (amask_on_ack),
        .thr_interval (thr_interval),
        .mask_next    (mask_next),
        .t_running    (t_running),
        .t_expire     (t_expire),
        .cause_q      (cause_q),
        .asrt_pre     (asrt_pre),
        .t_load       (t_load),
        .t_cancel     (t_cancel)
    );

    irq_throttle #(.IV_W(IV_W)) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_256ns),
        .load     (t_load),
        .load_val (thr_interval),
        .cancel   (t_cancel),
        .running  (t_running),
        .expire   (t_expire)
    );

    // Read data register: captures the selected register on a read operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (acc_valid) begin
            case (op)
                OP_CAUSE_RD: rd_q <= cause_q;
                OP_MASK_RD:  rd_q <= {1'b0, mask_q};
                OP_AMASK_RD: rd_q <= {1'b0, amask_q};
                default:     ;
            endcase
        end
    end

    assign rd_data = rd_q;
    assign irq_out = cause_q[CAUSE_W-1];

endmodule

// File: rtl/irq_cause_chk.sv
// Module: checker for the interrupt cause and mask controller, bound to the top.
// Assumes the operation codes of irq_ctrl_pkg.
module irq_cause_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_256ns,
    input logic          acc_valid,
    input logic [2:0]    acc_op,
    input logic [CW-2:0] acc_wdata,
    input logic [CW-2:0] ev_post,
    input logic          ev_urgent,
    input logic          amask_on_ack,
    input logic          irq_out,
    input logic [CW-1:0] rd_data,
    input logic [CW-1:0] cause_q,
    input logic [CW-2:0] mask_q
);

    // R1: the line is low on the edge after a reset cycle.
    a_r1_low_after_reset: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    // R2: clearing all cause bits with nothing posted drops the line.
    a_r2_clear_all_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd1 && (&acc_wdata) && ev_post == '0) |=> !irq_out);

    // R4: a cause read while asserted with auto-mask enable clears the line.
    a_r4_read_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd0 && irq_out && amask_on_ack && ev_post == '0) |=> !irq_out);

    // R5: clearing every mask bit with nothing posted drops the line.
    a_r5_mask_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 3'd4 && (&acc_wdata) && ev_post == '0) |=> !irq_out);

    // R8: an urgent new unmasked cause with nothing unmasked pending raises the line.
    a_r8_urgent_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && ev_urgent && ((ev_post & ~cause_q[CW-2:0] & mask_q) != '0)
         && ((cause_q[CW-2:0] & mask_q) == '0)) |=> irq_out);

    // R11: read data holds when no read operation is issued.
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && (acc_op == 3'd0 || acc_op == 3'd6 || acc_op == 3'd7)) |=> $stable(rd_data));

    // R12: with no access, posting or tick the cause register holds.
    a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && ev_post == '0 && !tick_256ns) |=> $stable(cause_q));

endmodule

bind irq_cause_ctrl irq_cause_chk #(.CW(CAUSE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_256ns   (tick_256ns),
    .acc_valid    (acc_valid),
    .acc_op       (acc_op),
    .acc_wdata    (acc_wdata),
    .ev_post      (ev_post),
    .ev_urgent    (ev_urgent),
    .amask_on_ack (amask_on_ack),
    .irq_out      (irq_out),
    .rd_data      (rd_data),
    .cause_q      (cause_q),
    .mask_q       (mask_q)
);

// File: tb/sim_irq_cause_ctrl.sv
// Bench: directed corner cases, then seeded random traffic compared with a
// bench model of the requirements.
module sim_irq_cause_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_256ns = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_op = 3'd0;
    logic [30:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [30:0] ev_post = '0;
    logic        ev_urgent = 1'b0;
    logic [15:0] thr_interval = '0;
    logic        amask_on_ack = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model state
    logic [31:0] m_c = '0;
    logic [30:0] m_m = '0;
    logic [30:0] m_am = '0;
    logic        m_run = 1'b0;
    logic [15:0] m_cnt = '0;
    logic [31:0] m_rd = '0;

    irq_cause_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_256ns   (tick_256ns),
        .acc_valid    (acc_valid),
        .acc_op       (acc_op),
        .acc_wdata    (acc_wdata),
        .rd_data      (rd_data),
        .ev_post      (ev_post),
        .ev_urgent    (ev_urgent),
        .thr_interval (thr_interval),
        .amask_on_ack (amask_on_ack),
        .irq_out      (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bench model: expiry, host operation, merged posting, timer update.
    task automatic model_step();
        logic        exp_now, ld, cn;
        logic [31:0] c;
        logic [30:0] m, am, pb, nb;
        exp_now = m_run && tick_256ns && (m_cnt == 16'd1);
        c = m_c;
        if (exp_now) c[31] = 1'b1;
        m = m_m;
        am = m_am;
        if (acc_valid) begin
            case (acc_op)
                3'd0: begin
                    m_rd = m_c;
                    if (c[31]) m = m & am;
                    if (m == '0 || (c[31] && amask_on_ack)) c = '0;
                end
                3'd1: begin
                    if (c[31]) m = m & am;
                    c[30:0] = c[30:0] & ~acc_wdata;
                    if (c[30:0] == '0) c[31] = 1'b0;
                end
                3'd3: begin
                    m = m | acc_wdata;
                    if ((c[30:0] & m) == '0) c[31] = 1'b0;
                end
                3'd4: begin
                    m = m & ~acc_wdata;
                    if ((c[30:0] & m) == '0) c[31] = 1'b0;
                end
                3'd5: am = acc_wdata;
                3'd6: m_rd = {1'b0, m_m};
                3'd7: m_rd = {1'b0, m_am};
                default: ;
            endcase
        end
        pb = ev_post | ((acc_valid && acc_op == 3'd2) ? acc_wdata : 31'd0);
        nb = pb & ~c[30:0];
        ld = 1'b0;
        cn = 1'b0;
        if (nb != '0) begin
            if (((c[30:0] & m) == '0) && ((nb & m) != '0)) begin
                if (thr_interval == '0 || ev_urgent) begin
                    c[31] = 1'b1;
                    cn = 1'b1;
                end else if (!m_run || exp_now) begin
                    ld = 1'b1;
                end
            end
            c[30:0] = c[30:0] | nb;
        end
        if (c[30:0] == '0) cn = 1'b1;
        if (cn) begin
            m_run = 1'b0; m_cnt = '0;
        end else if (ld) begin
            m_run = 1'b1; m_cnt = thr_interval;
        end else if (exp_now) begin
            m_run = 1'b0; m_cnt = '0;
        end else if (m_run && tick_256ns) begin
            m_cnt = m_cnt - 16'd1;
        end
        m_c = c;
        m_m = m;
        m_am = am;
    endtask

    // One cycle: drive at the falling edge, step the model, wait for the next falling edge.
    task automatic cyc(input logic v, input logic [2:0] op, input logic [30:0] w,
                       input logic [30:0] ev, input logic now, input logic tk);
        acc_valid = v;
        acc_op = op;
        acc_wdata = w;
        ev_post = ev;
        ev_urgent = now;
        tick_256ns = tk;
        model_step();
        @(negedge clk);
        acc_valid = 1'b0;
        ev_post = '0;
        ev_urgent = 1'b0;
        tick_256ns = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 rd after reset", rd_data, 32'd0);
        cyc(1, 3'd6, '0, '0, 0, 0);
        chk("R1 mask after reset", rd_data, 32'd0);

        // R8: interval zero asserts on the next edge
        cyc(1, 3'd3, 31'h7fffffff, '0, 0, 0);
        cyc(0, 3'd0, '0, 31'h1, 0, 0);
        chk("R8 zero interval asserts", {31'd0, irq_out}, 32'd1);
        // R6: further post only ORs in
        cyc(0, 3'd0, '0, 31'h3, 0, 0);
        chk("R6 line kept", {31'd0, irq_out}, 32'd1);
        // R3/R4: read with zero auto-mask zeroes mask and clears
        cyc(1, 3'd0, '0, '0, 0, 0);
        chk("R4 read value", rd_data, 32'h80000003);
        chk("R4 cleared with zero mask", {31'd0, irq_out}, 32'd0);
        cyc(1, 3'd6, '0, '0, 0, 0);
        chk("R3 mask ANDed with auto-mask", rd_data, 32'd0);

        // R7: masked cause recorded silently
        cyc(0, 3'd0, '0, 31'h4, 0, 0);
        chk("R7 masked no assert", {31'd0, irq_out}, 32'd0);
        cyc(1, 3'd0, '0, '0, 0, 0);
        chk("R7 masked cause recorded", rd_data, 32'h00000004);
        cyc(1, 3'd0, '0, '0, 0, 0);
        chk("R4 clear on read", rd_data, 32'd0);

        // R11: auto-mask write and readback
        cyc(1, 3'd5, 31'h7fffffff, '0, 0, 0);
        cyc(1, 3'd7, '0, '0, 0, 0);
        chk("R11 auto-mask readback", rd_data, 32'h7fffffff);

        // R2: partial and full cause clear
        cyc(1, 3'd3, 31'hf, '0, 0, 0);
        cyc(0, 3'd0, '0, 31'h3, 0, 0);
        cyc(1, 3'd1, 31'h1, '0, 0, 0);
        chk("R2 partial clear keeps line", {31'd0, irq_out}, 32'd1);
        cyc(1, 3'd1, 31'h2, '0, 0, 0);
        chk("R2 last clear drops line", {31'd0, irq_out}, 32'd0);

        // R5: mask clear recheck drops the line
        cyc(0, 3'd0, '0, 31'h8, 0, 0);
        chk("R5 setup assert", {31'd0, irq_out}, 32'd1);
        cyc(1, 3'd4, 31'h8, '0, 0, 0);
        chk("R5 recheck drops", {31'd0, irq_out}, 32'd0);
        cyc(1, 3'd0, '0, '0, 0, 0);
        chk("R4 kept with live mask", rd_data, 32'h00000008);
        cyc(1, 3'd6, '0, '0, 0, 0);
        chk("R5 mask after clear", rd_data, 32'h00000007);
        cyc(1, 3'd1, 31'h8, '0, 0, 0);

        // R9: throttle of three ticks
        thr_interval = 16'd3;
        cyc(0, 3'd0, '0, 31'h1, 0, 0);
        chk("R9 no immediate assert", {31'd0, irq_out}, 32'd0);
        cyc(0, 3'd0, '0, '0, 0, 1);
        cyc(0, 3'd0, '0, '0, 0, 0);
        cyc(0, 3'd0, '0, '0, 0, 1);
        chk("R9 low before last tick", {31'd0, irq_out}, 32'd0);
        cyc(0, 3'd0, '0, '0, 0, 1);
        chk("R9 asserted on last tick", {31'd0, irq_out}, 32'd1);
        amask_on_ack = 1'b1;
        cyc(1, 3'd0, '0, '0, 0, 0);
        chk("R4 ack read clears", {31'd0, irq_out}, 32'd0);
        chk("R9 read value", rd_data, 32'h80000001);

        // R8: urgent post cancels a running timer
        cyc(0, 3'd0, '0, 31'h2, 0, 0);
        cyc(1, 3'd4, 31'h2, '0, 0, 0);
        cyc(0, 3'd0, '0, 31'h4, 1, 0);
        chk("R8 urgent asserts", {31'd0, irq_out}, 32'd1);
        cyc(1, 3'd1, 31'h6, '0, 0, 0);
        chk("R8 cleared", {31'd0, irq_out}, 32'd0);
        for (int i = 0; i < 4; i++) cyc(0, 3'd0, '0, '0, 0, 1);
        chk("R8 timer cancelled", {31'd0, irq_out}, 32'd0);

        // R10: host set merged with events
        thr_interval = 16'd0;
        cyc(1, 3'd2, 31'h1, 31'h4, 0, 0);
        chk("R10 merged post asserts", {31'd0, irq_out}, 32'd1);
        cyc(1, 3'd0, '0, '0, 0, 0);
        chk("R10 merged cause value", rd_data, 32'h80000005);

        // R12: seeded random traffic against the model
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'd1234);
        end
        for (int k = 0; k < 4000; k++) begin
            logic v, now, tk;
            logic [2:0] op;
            logic [30:0] w, ev;
            if (k % 500 == 0) begin
                thr_interval = 16'($urandom % 4);
                amask_on_ack = 1'($urandom % 2);
            end
            v = ($urandom % 3) == 0;
            op = 3'($urandom % 8);
            w = ($urandom % 8 == 0) ? 31'h7fffffff : 31'($urandom % 256);
            ev = ($urandom % 4 == 0) ? (31'd1 << ($urandom % 8)) : 31'd0;
            now = ($urandom % 6) == 0;
            tk = ($urandom % 3) == 0;
            cyc(v, op, w, ev, now, tk);
            chk("R12 irq vs model", {31'd0, irq_out}, {31'd0, m_c[31]});
            chk("R12 rd vs model", rd_data, m_rd);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule